// File: doc/BRIEF.md
# Multi-Mode Timer Channel Start Sequencer

This block is one 16-bit timer channel. Its counter starts in a way that depends on the operating mode chosen when the channel is started. A software start pulse enables the channel. A count-clock enable strobe advances the counter. An external start trigger releases the one-count modes. A capture input copies the running count into the channel's data register. The data register is also written from a plain write port.

There are five modes. Interval and event counter modes count down and reload. Capture mode counts up from zero and records the count on capture edges. One-count mode and capture plus one-count mode wait armed for the external trigger, run once, and then return to the armed wait. The interrupt output is a single-cycle pulse when a down-count reaches zero or when a capture occurs.

The sequencer has four named states:
- `S_IDLE`: stopped.
- `S_ARM`: waiting for the external trigger.
- `S_PEND`: waiting for the first count clock, which loads or clears the counter.
- `S_RUN`: counting.

The named transitions are:
- start: from `S_IDLE` to `S_PEND`, `S_ARM` or `S_RUN`, depending on the mode.
- trigger: from `S_ARM` to `S_PEND`.
- first tick: from `S_PEND` to `S_RUN`.
- finish: from `S_RUN` to `S_ARM`, in the one-count modes.
- stop: from any state to `S_IDLE`.

Top module: `tmr_chan_seq`

## Requirements
- R1: After reset the count, the data register, the enable flag and the interrupt are all 0, and the state is `S_IDLE`.
- R2: In interval mode (mode code 0), start raises the enable flag and leaves the count unchanged. The first count-clock strobe copies the data register into the count, and each later strobe decrements it.
- R3: In event counter mode (mode code 1), the start pulse itself copies the data register into the count at the same clock edge. Each later strobe decrements it.
- R4: In event counter mode, the external trigger never starts the channel and never changes the count. Only the start pulse begins operation.
- R5: In capture mode (mode code 2), start leaves the count unchanged. The first strobe clears the count to 0, and each later strobe increments it.
- R6: In interval and event counter modes, a strobe that takes the count from 1 to 0 raises the interrupt for exactly one cycle. The next strobe reloads the count from the data register.
- R7: In capture mode, a rising edge on the capture input copies the count into the data register and pulses the interrupt for one cycle, and counting continues. A write strobe loads the data register when no capture occurs in that cycle.
- R8: A stop pulse has priority over every other input. It drops the enable flag, moves the channel to `S_IDLE`, and freezes the count: later strobes leave it unchanged.
- R9: In one-count mode (mode code 3) and capture plus one-count mode (mode code 4), start enters `S_ARM`. Count-clock strobes leave the count unchanged until the external trigger arrives.
- R10: In one-count mode, the first strobe after the trigger loads the data register and later strobes decrement. The strobe that reaches 0 pulses the interrupt and returns the channel to `S_ARM`, with the count held at 0.
- R11: An external trigger that arrives while one-count counting is in progress (`S_RUN`) is ignored, and decrementing carries on.
- R12: In capture plus one-count mode, the first strobe after the trigger clears the count and later strobes increment it. A capture edge copies the count into the data register, pulses the interrupt, and returns the channel to `S_ARM`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Software start pulse; the mode is sampled with it |
| stop_i | input | 1 | Software stop pulse |
| tick_i | input | 1 | Count-clock enable strobe |
| trig_i | input | 1 | External start trigger for the one-count modes |
| cap_i | input | 1 | Capture input; acts on its rising edge |
| mode_i | input | 3 | Mode code: 0 interval, 1 event, 2 capture, 3 one-count, 4 capture plus one-count |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 16 | Data register write value |
| count_o | output | 16 | Current counter value |
| dreg_o | output | 16 | Data register (reload or capture value) |
| en_o | output | 1 | Enable status flag |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach from the ports is a one-count run. The channel must be armed, triggered, and then hit by a second trigger while it is still decrementing, and later reach zero and fall back into the armed wait. The stimulus gets there with a small data register value, so that zero comes within a few strobes. It places trigger pulses on chosen cycles both during the run and after the return to `S_ARM`. It also applies count-clock strobes while the channel is armed, to show that they have no effect until the trigger arrives.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [2:0] {
        M_INTERVAL = 3'd0,
        M_EVENT    = 3'd1,
        M_CAPTURE  = 3'd2,
        M_ONESHOT  = 3'd3,
        M_CAPONE   = 3'd4
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_PEND = 2'd2,
        S_RUN  = 2'd3
    } seq_state_t;

    function automatic mode_t decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return M_EVENT;
            3'd2:    return M_CAPTURE;
            3'd3:    return M_ONESHOT;
            3'd4:    return M_CAPONE;
            default: return M_INTERVAL;
        endcase
    endfunction

    function automatic logic counts_up(input mode_t m);
        return (m == M_CAPTURE) || (m == M_CAPONE);
    endfunction

endpackage

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    output logic rise_o
);
    logic cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= 1'b0;
        else        cap_q <= cap_i;
    end

    assign rise_o = cap_i & ~cap_q;
endmodule

// File: rtl/tmr_cnt_dp.sv
module tmr_cnt_dp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic         clr_i,
    input  logic         dec_i,
    input  logic         inc_i,
    input  logic         cap_wr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] dreg_o,
    output logic         zero_o,
    output logic         one_o
);
    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] dreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (ld_i)   cnt_q <= dreg_q;
        else if (dec_i)  cnt_q <= cnt_q - STEP;
        else if (inc_i)  cnt_q <= cnt_q + STEP;
    end

    // A capture takes the data register ahead of a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         dreg_q <= '0;
        else if (cap_wr_i)  dreg_q <= cnt_q;
        else if (wr_i)      dreg_q <= wdata_i;
    end

    assign cnt_o  = cnt_q;
    assign dreg_o = dreg_q;
    assign zero_o = (cnt_q == '0);
    assign one_o  = (cnt_q == STEP);
endmodule

// File: rtl/tmr_seq_fsm.sv
module tmr_seq_fsm
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       tick_i,
    input  logic       trig_i,
    input  logic       cap_rise_i,
    input  logic [2:0] mode_i,
    input  logic       cnt_zero_i,
    input  logic       cnt_one_i,
    output logic       ld_o,
    output logic       clr_o,
    output logic       dec_o,
    output logic       inc_o,
    output logic       cap_wr_o,
    output logic       irq_o,
    output seq_state_t st_o,
    output mode_t      md_o
);
    seq_state_t st_q, st_d;
    mode_t      md_q, md_d;
    logic       irq_q, irq_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            md_q  <= M_INTERVAL;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            md_q  <= md_d;
            irq_q <= irq_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        st_d     = st_q;
        md_d     = md_q;
        ld_o     = 1'b0;
        clr_o    = 1'b0;
        dec_o    = 1'b0;
        inc_o    = 1'b0;
        cap_wr_o = 1'b0;
        irq_d    = 1'b0;
        if (stop_i) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        md_d = decode_mode(mode_i);
                        case (decode_mode(mode_i))
                            M_EVENT: begin
                                ld_o = 1'b1;
                                st_d = S_RUN;
                            end
                            M_ONESHOT, M_CAPONE: st_d = S_ARM;
                            default:             st_d = S_PEND;
                        endcase
                    end
                end
                S_ARM: begin
                    if (trig_i) st_d = S_PEND;
                end
                S_PEND: begin
                    if (tick_i) begin
                        if (counts_up(md_q)) clr_o = 1'b1;
                        else                 ld_o  = 1'b1;
                        st_d = S_RUN;
                    end
                end
                S_RUN: begin
                    if (counts_up(md_q)) begin
                        if (cap_rise_i) begin
                            cap_wr_o = 1'b1;
                            irq_d    = 1'b1;
                            if (md_q == M_CAPONE) st_d = S_ARM;
                        end
                        if (tick_i && (st_d == S_RUN)) inc_o = 1'b1;
                    end else if (tick_i) begin
                        if (cnt_zero_i) begin
                            if (md_q == M_ONESHOT) st_d = S_ARM;
                            else                   ld_o = 1'b1;
                        end else begin
                            dec_o = 1'b1;
                            if (cnt_one_i) begin
                                irq_d = 1'b1;
                                if (md_q == M_ONESHOT) st_d = S_ARM;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign irq_o = irq_q;
    assign st_o  = st_q;
    assign md_o  = md_q;
endmodule

// File: rtl/tmr_chan_seq.sv
module tmr_chan_seq
    import tmr_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         tick_i,
    input  logic         trig_i,
    input  logic         cap_i,
    input  logic [2:0]   mode_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] dreg_o,
    output logic         en_o,
    output logic         irq_o
);
    logic       cap_rise;
    logic       ld, clr, dec, inc, cap_wr;
    logic       cnt_zero, cnt_one;
    seq_state_t st;
    mode_t      md;

    tmr_cap_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_i),
        .rise_o (cap_rise)
    );

    tmr_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .tick_i     (tick_i),
        .trig_i     (trig_i),
        .cap_rise_i (cap_rise),
        .mode_i     (mode_i),
        .cnt_zero_i (cnt_zero),
        .cnt_one_i  (cnt_one),
        .ld_o       (ld),
        .clr_o      (clr),
        .dec_o      (dec),
        .inc_o      (inc),
        .cap_wr_o   (cap_wr),
        .irq_o      (irq_o),
        .st_o       (st),
        .md_o       (md)
    );

    tmr_cnt_dp #(.W(W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (ld),
        .clr_i    (clr),
        .dec_i    (dec),
        .inc_i    (inc),
        .cap_wr_i (cap_wr),
        .wr_i     (wr_i),
        .wdata_i  (wdata_i),
        .cnt_o    (count_o),
        .dreg_o   (dreg_o),
        .zero_o   (cnt_zero),
        .one_o    (cnt_one)
    );

    assign en_o = (st != S_IDLE);
endmodule

// File: rtl/tmr_chan_seq_chk.sv
module tmr_chan_seq_chk
    import tmr_chan_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         stop_i,
    input logic         tick_i,
    input logic         trig_i,
    input logic [2:0]   mode_i,
    input logic [W-1:0] count_o,
    input logic [W-1:0] dreg_o,
    input logic         en_o,
    input logic         irq_o,
    input seq_state_t   st,
    input mode_t        md
);
    localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

    a_r1_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !en_o);

    a_r3_event_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && start_i && !stop_i && mode_i == 3'd1) |=> (count_o == $past(dreg_o)));

    a_r4_trig_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !start_i && trig_i) |=> !en_o);

    a_r5_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PEND && tick_i && !stop_i && counts_up(md)) |=> (count_o == '0));

    a_r6_reach_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && !counts_up(md) && tick_i && !stop_i && count_o == ONE_V)
        |=> (count_o == '0 && irq_o));

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_o);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !start_i) |=> $stable(count_o));

    a_r9_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARM) |=> $stable(count_o));

    a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN) |=> (st != S_PEND));
endmodule

bind tmr_chan_seq tmr_chan_seq_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .tick_i  (tick_i),
    .trig_i  (trig_i),
    .mode_i  (mode_i),
    .count_o (count_o),
    .dreg_o  (dreg_o),
    .en_o    (en_o),
    .irq_o   (irq_o),
    .st      (st),
    .md      (md)
);

// File: tb/sim_tmr_chan_seq.sv
`timescale 1ns/1ps
module sim_tmr_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0, tick_i = 1'b0;
    logic        trig_i = 1'b0, cap_i = 1'b0, wr_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] wdata_i = '0;
    logic [15:0] count_o, dreg_o;
    logic        en_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int dr = 0;

    typedef struct {
        int    cnt;
        bit    irq;
        bit    en;
        int    dreg;
        string rq;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    tmr_chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .tick_i(tick_i), .trig_i(trig_i), .cap_i(cap_i), .mode_i(mode_i),
        .wr_i(wr_i), .wdata_i(wdata_i), .count_o(count_o), .dreg_o(dreg_o),
        .en_o(en_o), .irq_o(irq_o)
    );

    // Driver: apply one cycle of inputs and queue the values expected after the edge
    task automatic step(input bit s, input bit p, input bit t, input bit g, input bit c,
                        input int ec, input bit ei, input bit een, input string rq);
        exp_t e;
        @(negedge clk);
        start_i = s; stop_i = p; tick_i = t; trig_i = g; cap_i = c; wr_i = 1'b0;
        e.cnt = ec; e.irq = ei; e.en = een; e.dreg = dr; e.rq = rq;
        q.push_back(e);
    endtask

    task automatic wrd(input int v);
        @(negedge clk);
        start_i = 0; stop_i = 0; tick_i = 0; trig_i = 0; cap_i = 0;
        wr_i = 1'b1; wdata_i = 16'(v);
        dr = v;
    endtask

    // Monitor: pop and compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(count_o) != e.cnt || irq_o != e.irq || en_o != e.en ||
                    int'(dreg_o) != e.dreg) begin
                    failures++;
                    $display("FAIL %s: actual cnt=%0d irq=%0b en=%0b dreg=%0d expected cnt=%0d irq=%0b en=%0b dreg=%0d",
                             e.rq, count_o, irq_o, en_o, dreg_o, e.cnt, e.irq, e.en, e.dreg);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,0, 0,0,0, "R1 reset");

        // Interval mode
        wrd(3); mode_i = 3'd0;
        step(1,0,0,0,0, 0,0,1, "R2 start defers load");
        step(0,0,0,0,0, 0,0,1, "R2 waits for tick");
        step(0,0,1,0,0, 3,0,1, "R2 first tick loads");
        step(0,0,1,0,0, 2,0,1, "R2 decrement");
        step(0,0,1,0,0, 1,0,1, "R2 decrement");
        step(0,0,1,0,0, 0,1,1, "R6 zero interrupt");
        step(0,0,0,0,0, 0,0,1, "R6 interrupt single cycle");
        step(0,0,1,0,0, 3,0,1, "R6 reload");
        step(0,0,1,0,0, 2,0,1, "R6 after reload");
        step(0,1,0,0,0, 2,0,0, "R8 stop");
        step(0,0,1,0,0, 2,0,0, "R8 frozen");

        // Event counter mode
        wrd(5); mode_i = 3'd1;
        step(0,0,0,1,0, 2,0,0, "R4 trigger does not start");
        step(1,0,0,0,0, 5,0,1, "R3 immediate load");
        step(0,0,0,1,0, 5,0,1, "R4 trigger no effect");
        step(0,0,1,0,0, 4,0,1, "R3 decrement");
        step(0,1,0,0,0, 4,0,0, "R8 stop");

        // Capture mode
        mode_i = 3'd2;
        step(1,0,0,0,0, 4,0,1, "R5 start holds count");
        step(0,0,1,0,0, 0,0,1, "R5 first tick clears");
        step(0,0,1,0,0, 1,0,1, "R5 increment");
        step(0,0,1,0,0, 2,0,1, "R5 increment");
        dr = 2;
        step(0,0,0,0,1, 2,1,1, "R7 capture");
        step(0,0,0,0,0, 2,0,1, "R7 interrupt single cycle");
        step(0,0,1,0,0, 3,0,1, "R7 keeps counting");
        step(0,1,0,0,0, 3,0,0, "R8 stop");

        // One-count mode
        wrd(2); mode_i = 3'd3;
        step(1,0,0,0,0, 3,0,1, "R9 start arms");
        step(0,0,1,0,0, 3,0,1, "R9 tick ignored while armed");
        step(0,0,0,1,0, 3,0,1, "R9 trigger");
        step(0,0,1,0,0, 2,0,1, "R10 first tick loads");
        step(0,0,0,1,0, 2,0,1, "R11 trigger while running");
        step(0,0,1,0,0, 1,0,1, "R11 decrement not reload");
        step(0,0,1,0,0, 0,1,1, "R10 zero interrupt");
        step(0,0,1,0,0, 0,0,1, "R10 back to armed");
        step(0,0,0,1,0, 0,0,1, "R10 retrigger");
        step(0,0,1,0,0, 2,0,1, "R10 reload after retrigger");
        step(0,1,0,0,0, 2,0,0, "R8 stop");

        // Capture plus one-count mode
        mode_i = 3'd4;
        step(1,0,0,0,0, 2,0,1, "R9 start arms");
        step(0,0,1,0,0, 2,0,1, "R9 tick ignored while armed");
        step(0,0,0,1,0, 2,0,1, "R12 trigger");
        step(0,0,1,0,0, 0,0,1, "R12 first tick clears");
        step(0,0,1,0,0, 1,0,1, "R12 increment");
        dr = 1;
        step(0,0,0,0,1, 1,1,1, "R12 capture");
        step(0,0,0,0,0, 1,0,1, "R12 interrupt single cycle");
        step(0,0,1,0,0, 1,0,1, "R12 back to armed");
        step(0,1,0,0,0, 1,0,0, "R8 stop");

        step(0,0,0,0,0, 1,0,0, "R8 idle hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule